// File: doc/BRIEF.md
# Two-Pattern At-Speed Scan Test Sequencer

This block drives a plain multiplexed scan chain, one without hold latches, through a two-pattern delay test. It first shifts the initial pattern into the chain at a slow rate. It then forms the second pattern in one of two ways, chosen at start. In shift-launch mode it applies one more scan shift. In capture-launch mode it applies one functional clock. After that it captures the circuit's response one rated period after the launch. Finally it shifts the captured state out at the slow rate and streams it bit by bit to the tester side.

The chain is clocked from a single base clock through two single-cycle enable pulses. The slow enable marks shift edges. The rated enable marks the launch and capture edges, and no other edge. The slow and rated periods are counts of base-clock cycles, latched together with the mode and the chain length when a test starts. A flag warns when a shift-launch test is asked to run with a rated period too short for scan enable to settle between launch and capture.

Top module: `atspeed_ctl`

## Requirements
- R1: After reset, scan_en, slow_ce, rated_ce, pat_take, resp_valid, done, busy and per_err are all 0.
- R2: A start sampled while idle begins a load of chain_len slow_ce pulses with scan_en high. Each load pulse also raises pat_take, because it consumes one pattern bit from pat_in. The first pulse comes slow_per base cycles after the start edge, and each later pulse follows the one before it by slow_per cycles.
- R3: When launch_mode is 0 (shift launch), the launch edge is one further shift: a rated_ce pulse with scan_en high and pat_take high. scan_en is low at the capture edge that follows.
- R4: When launch_mode is 1 (capture launch), scan_en is low for exactly two edges, the launch and the capture, and both are rated_ce pulses. No pattern bit is consumed at launch.
- R5: The launch edge follows the last load edge by slow_per cycles. The capture edge follows the launch by rated_per cycles. rated_ce pulses exactly twice per test, and never in the same cycle as slow_ce.
- R6: The capture is followed, slow_per cycles apart, by chain_len unload edges with scan_en high. At each unload edge resp_in is sampled. The cycle after that edge, resp_out shows the sampled value and resp_valid is high.
- R7: done is high for one cycle, the cycle after the last unload edge. busy is high from the start edge until that edge.
- R8: A start that arrives while busy is ignored. The running test keeps its latched settings, and no further edges follow its end.
- R9: per_err is updated at each accepted start. It is set when launch_mode is 0 and the effective rated_per is below SE_SETTLE, and it is cleared otherwise.
- R10: A slow_per or rated_per of 0 acts as 1, and a chain_len of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test when idle |
| launch_mode | input | 1 | 0 = shift launch, 1 = capture launch |
| chain_len | input | LEN_W | Number of cells in the scan chain |
| slow_per | input | PER_W | Slow edge spacing in base cycles |
| rated_per | input | PER_W | Launch-to-capture spacing in base cycles |
| pat_in | input | 1 | Current pattern bit from the source |
| resp_in | input | 1 | Serial output of the last chain cell |
| scan_en | output | 1 | Chain shift select (1 = shift) |
| scan_si | output | 1 | Serial data into the first chain cell |
| pat_take | output | 1 | Pattern bit consumed on this edge |
| slow_ce | output | 1 | Slow clock-enable pulse |
| rated_ce | output | 1 | Rated clock-enable pulse |
| resp_out | output | 1 | Unloaded response bit |
| resp_valid | output | 1 | resp_out holds a new bit |
| done | output | 1 | One-cycle end-of-test pulse |
| busy | output | 1 | Test in progress |
| per_err | output | 1 | Rated period shorter than scan-enable settling allowance |

## Verification
Every enable pulse is taken by the chain at the clock edge that ends the cycle in which it is seen. The bench therefore timestamps each pulse as the index of that edge. The first pulse is due slow_per edges after the edge that samples start. The capture is due rated_per edges after the launch, and every other gap is slow_per. resp_valid and done are due in the cycle after the edge they follow, so the bench requires each of them to carry the same timestamp as that edge. Each run compares the full list of edge times, scan_en levels and response bits against values worked out from the pattern, the length and the two periods.

// File: rtl/atspeed_pkg.sv
// Shared types for the at-speed scan test sequencer.
package atspeed_pkg;
    // Phases of one two-pattern test
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LAUNCH,
        ST_CAPT,
        ST_UNLOAD
    } seq_st_e;

    // How the second pattern is formed
    typedef enum logic {
        LAUNCH_SHIFT = 1'b0,
        LAUNCH_CAPT  = 1'b1
    } launch_mode_e;
endpackage

// File: rtl/atspeed_period_timer.sv
// Down-counter that sets the spacing between chain edges.
// Assumes: reload is pulsed on the cycle an edge is taken; a period of 0 acts as 1.
module atspeed_period_timer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [PER_W-1:0] period,
    output logic             expired
);
    logic [PER_W-1:0] cnt;

    // Load period-1 on reload, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (reload)
            cnt <= (period == '0) ? '0 : period - PER_W'(1);
        else if (cnt != '0)
            cnt <= cnt - PER_W'(1);
    end

    assign expired = (cnt == '0);

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && cnt == '0) |=> (cnt == '0)) else $error("timer left zero without reload"); // R5
endmodule

// File: rtl/atspeed_seq.sv
// Phase sequencer: load, launch, capture, unload.
// Assumes: the chain takes an edge in each cycle where slow_ce or rated_ce is high;
// settings are latched at the accepted start and held for the whole test.
module atspeed_seq
    import atspeed_pkg::*;
#(
    parameter int LEN_W     = 6,
    parameter int PER_W     = 8,
    parameter int SE_SETTLE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             launch_mode,
    input  logic [LEN_W-1:0] chain_len,
    input  logic [PER_W-1:0] slow_per,
    input  logic [PER_W-1:0] rated_per,
    input  logic             tmr_expired,
    output logic             tmr_reload,
    output logic [PER_W-1:0] tmr_period,
    output logic             scan_en,
    output logic             slow_ce,
    output logic             rated_ce,
    output logic             pat_take,
    output logic             unload_edge,
    output logic             last_unload,
    output logic             busy,
    output logic             per_err
);
    localparam logic [PER_W-1:0] SETTLE_P = PER_W'(SE_SETTLE);

    seq_st_e          state;
    launch_mode_e     mode_q;
    logic [LEN_W-1:0] len_q;
    logic [PER_W-1:0] slow_q;
    logic [PER_W-1:0] rated_q;
    logic [LEN_W-1:0] bitc;
    logic             scan_en_q;
    logic             per_err_q;
    logic             tick;
    logic             bit_last;
    logic             accept;
    logic [PER_W-1:0] rated_eff;

    // Decode the edge of the current phase and the accepted start
    always_comb begin
        accept    = (state == ST_IDLE) && start;
        tick      = (state != ST_IDLE) && tmr_expired;
        bit_last  = (bitc == len_q - LEN_W'(1));
        rated_eff = (rated_per == '0) ? PER_W'(1) : rated_per;
    end

    // Enable pulses, pattern consumption and unload markers
    always_comb begin
        slow_ce     = tick && (state == ST_LOAD || state == ST_UNLOAD);
        rated_ce    = tick && (state == ST_LAUNCH || state == ST_CAPT);
        pat_take    = tick && (state == ST_LOAD ||
                               (state == ST_LAUNCH && mode_q == LAUNCH_SHIFT));
        unload_edge = tick && (state == ST_UNLOAD);
        last_unload = unload_edge && bit_last;
    end

    // Spacing to the next edge: rated only for the launch-to-capture gap
    always_comb begin
        tmr_reload = accept || tick;
        if (state == ST_IDLE)
            tmr_period = slow_per;
        else if (state == ST_LAUNCH)
            tmr_period = rated_q;
        else
            tmr_period = slow_q;
    end

    // Phase sequencing, bit counting and scan-enable control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode_q    <= LAUNCH_SHIFT;
            len_q     <= LEN_W'(1);
            slow_q    <= '0;
            rated_q   <= '0;
            bitc      <= '0;
            scan_en_q <= 1'b0;
            per_err_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    mode_q    <= launch_mode_e'(launch_mode);
                    len_q     <= (chain_len == '0) ? LEN_W'(1) : chain_len;
                    slow_q    <= slow_per;
                    rated_q   <= rated_per;
                    bitc      <= '0;
                    scan_en_q <= 1'b1;
                    per_err_q <= (launch_mode == 1'b0) && (rated_eff < SETTLE_P);
                    state     <= ST_LOAD;
                end
                ST_LOAD: if (tick) begin
                    if (bit_last) begin
                        bitc  <= '0;
                        state <= ST_LAUNCH;
                        if (mode_q == LAUNCH_CAPT)
                            scan_en_q <= 1'b0;
                    end else begin
                        bitc <= bitc + LEN_W'(1);
                    end
                end
                ST_LAUNCH: if (tick) begin
                    scan_en_q <= 1'b0;
                    state     <= ST_CAPT;
                end
                ST_CAPT: if (tick) begin
                    scan_en_q <= 1'b1;
                    state     <= ST_UNLOAD;
                end
                ST_UNLOAD: if (tick) begin
                    if (bit_last) begin
                        bitc      <= '0;
                        scan_en_q <= 1'b0;
                        state     <= ST_IDLE;
                    end else begin
                        bitc <= bitc + LEN_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign scan_en = scan_en_q;
    assign busy    = (state != ST_IDLE);
    assign per_err = per_err_q;

    AST_SHIFT_SE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        slow_ce |-> scan_en_q) else $error("slow edge without scan enable"); // R2
    AST_LOS_LAUNCH_SE: assert property (@(posedge clk) disable iff (!rst_n)
        (rated_ce && state == ST_LAUNCH && mode_q == LAUNCH_SHIFT) |-> scan_en_q)
        else $error("shift launch without scan enable"); // R3
    AST_CAPT_SE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rated_ce && state == ST_CAPT) |-> !scan_en_q) else $error("capture in scan mode"); // R3
    AST_LOC_LAUNCH_SE: assert property (@(posedge clk) disable iff (!rst_n)
        (rated_ce && state == ST_LAUNCH && mode_q == LAUNCH_CAPT) |-> !scan_en_q)
        else $error("functional launch in scan mode"); // R4
    AST_BITC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bitc < len_q)) else $error("bit counter out of range"); // R2
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (mode_q == $past(mode_q) && len_q == $past(len_q)))
        else $error("settings changed while busy"); // R8
endmodule

// File: rtl/atspeed_resp.sv
// Response stream register and end-of-test pulse.
// Assumes: unload_edge marks the cycle in which the chain shifts one bit out.
module atspeed_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic unload_edge,
    input  logic last_unload,
    input  logic resp_in,
    output logic resp_out,
    output logic resp_valid,
    output logic done
);
    // Sample the chain tail at each unload edge and flag the final one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_out   <= 1'b0;
            resp_valid <= 1'b0;
            done       <= 1'b0;
        end else begin
            if (unload_edge)
                resp_out <= resp_in;
            resp_valid <= unload_edge;
            done       <= last_unload;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R7
    AST_DONE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> resp_valid) else $error("done without final bit"); // R7
endmodule

// File: rtl/atspeed_ctl.sv
// Top of the two-pattern at-speed scan test sequencer.
// Assumes: the chain and the logic under test are outside; both use clk qualified by
// slow_ce or rated_ce, and resp_in is the last cell's output.
module atspeed_ctl
    import atspeed_pkg::*;
#(
    parameter int LEN_W     = 6,
    parameter int PER_W     = 8,
    parameter int SE_SETTLE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             launch_mode,
    input  logic [LEN_W-1:0] chain_len,
    input  logic [PER_W-1:0] slow_per,
    input  logic [PER_W-1:0] rated_per,
    input  logic             pat_in,
    input  logic             resp_in,
    output logic             scan_en,
    output logic             scan_si,
    output logic             pat_take,
    output logic             slow_ce,
    output logic             rated_ce,
    output logic             resp_out,
    output logic             resp_valid,
    output logic             done,
    output logic             busy,
    output logic             per_err
);
    logic             tmr_reload;
    logic             tmr_expired;
    logic [PER_W-1:0] tmr_period;
    logic             unload_edge;
    logic             last_unload;

    atspeed_period_timer #(.PER_W(PER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (tmr_reload),
        .period  (tmr_period),
        .expired (tmr_expired)
    );

    atspeed_seq #(.LEN_W(LEN_W), .PER_W(PER_W), .SE_SETTLE(SE_SETTLE)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .launch_mode (launch_mode),
        .chain_len   (chain_len),
        .slow_per    (slow_per),
        .rated_per   (rated_per),
        .tmr_expired (tmr_expired),
        .tmr_reload  (tmr_reload),
        .tmr_period  (tmr_period),
        .scan_en     (scan_en),
        .slow_ce     (slow_ce),
        .rated_ce    (rated_ce),
        .pat_take    (pat_take),
        .unload_edge (unload_edge),
        .last_unload (last_unload),
        .busy        (busy),
        .per_err     (per_err)
    );

    atspeed_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .unload_edge (unload_edge),
        .last_unload (last_unload),
        .resp_in     (resp_in),
        .resp_out    (resp_out),
        .resp_valid  (resp_valid),
        .done        (done)
    );

    // Feed pattern bits only when one is consumed; unload shifts in zeros
    assign scan_si = pat_take & pat_in;

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(slow_ce && rated_ce)) else $error("both enables at once"); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(slow_ce || rated_ce)) else $error("edge while idle"); // R8
endmodule

// File: tb/atspeed_ctl_test.sv
module atspeed_ctl_test;
    localparam int LEN_W = 5;
    localparam int PER_W = 4;
    localparam int SETTLE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic launch_mode = 1'b0;
    logic [LEN_W-1:0] chain_len = '0;
    logic [PER_W-1:0] slow_per = '0;
    logic [PER_W-1:0] rated_per = '0;
    logic pat_in, resp_in;
    logic scan_en, scan_si, pat_take, slow_ce, rated_ce;
    logic resp_out, resp_valid, done, busy, per_err;

    always #5 clk = ~clk;

    atspeed_ctl #(.LEN_W(LEN_W), .PER_W(PER_W), .SE_SETTLE(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .launch_mode(launch_mode),
        .chain_len(chain_len), .slow_per(slow_per), .rated_per(rated_per),
        .pat_in(pat_in), .resp_in(resp_in), .scan_en(scan_en), .scan_si(scan_si),
        .pat_take(pat_take), .slow_ce(slow_ce), .rated_ce(rated_ce),
        .resp_out(resp_out), .resp_valid(resp_valid), .done(done),
        .busy(busy), .per_err(per_err)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // Chain and logic-under-test model
    logic [15:0] chain = '0;
    logic [31:0] pat = '0;
    int tb_len = 1;
    int ptake = 0;
    int pbase = 0;

    function automatic logic [15:0] shift_in(logic [15:0] x, logic si, int len);
        logic [15:0] y = '0;
        y[0] = si;
        for (int i = 1; i < 16; i++) if (i < len) y[i] = x[i-1];
        return y;
    endfunction

    function automatic logic [15:0] logic_ut(logic [15:0] x, int len);
        logic [15:0] y = '0;
        for (int i = 0; i < 16; i++) if (i < len) y[i] = x[(i+1) % len] ^ (i % 3 == 0);
        return y;
    endfunction

    assign pat_in  = pat[(ptake - pbase) & 31];
    assign resp_in = chain[tb_len-1];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (slow_ce || rated_ce)
            chain <= scan_en ? shift_in(chain, scan_si, tb_len) : logic_ut(chain, tb_len);
        if (pat_take) ptake <= ptake + 1;
    end

    // Event recorder, sampled mid-cycle
    int ev_t [64];
    bit ev_r [64];
    bit ev_se [64];
    int n_ev = 0;
    bit rb [64];
    int rv_t [64];
    int n_rb = 0;
    int n_done = 0;
    int done_t = 0;

    always @(negedge clk) begin
        if (slow_ce || rated_ce) begin
            if (n_ev < 64) begin
                ev_t[n_ev] = cyc + 1; ev_r[n_ev] = rated_ce; ev_se[n_ev] = scan_en;
            end
            n_ev++;
        end
        if (resp_valid) begin
            if (n_rb < 64) begin rb[n_rb] = resp_out; rv_t[n_rb] = cyc; end
            n_rb++;
        end
        if (done) begin n_done++; done_t = cyc; end
    end

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_test(bit mode, int len, int sp, int rp, logic [31:0] p, bit poke);
        int l_e, s_e, r_e, t, start_t, tmo, nexp, n_fin;
        logic [15:0] v1, v2, cap;
        bit ok;
        int first_bad;
        l_e = (len == 0) ? 1 : len;
        s_e = (sp == 0) ? 1 : sp;
        r_e = (rp == 0) ? 1 : rp;
        @(negedge clk);
        pat = p; tb_len = l_e; pbase = ptake;
        n_ev = 0; n_rb = 0; n_done = 0;
        launch_mode = mode; chain_len = LEN_W'(len);
        slow_per = PER_W'(sp); rated_per = PER_W'(rp);
        start = 1'b1; start_t = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            tmo = 0;
            while (n_ev < 2 && tmo < 2000) begin @(negedge clk); tmo++; end
            start = 1'b1; launch_mode = ~mode; chain_len = LEN_W'(3);
            slow_per = PER_W'(2); rated_per = PER_W'(1);
            @(negedge clk);
            start = 1'b0;
        end
        tmo = 0;
        while (n_done == 0 && tmo < 5000) begin @(negedge clk); tmo++; end
        if (n_done == 0) begin
            check(1'b0, "watchdog", tmo, 0);
            return;
        end
        // Expected contents
        v1 = '0;
        for (int j = 0; j < l_e; j++) v1[j] = p[l_e-1-j];
        v2 = mode ? logic_ut(v1, l_e) : shift_in(v1, p[l_e], l_e);
        cap = logic_ut(v2, l_e);
        nexp = 2 * l_e + 2;
        check(n_ev == nexp, "R2 R5 edge count", n_ev, nexp);
        // R2 R5 R6: edge timing
        ok = 1'b1; t = start_t; first_bad = -1;
        for (int i = 0; i < nexp && i < n_ev; i++) begin
            t += (i == l_e + 1) ? r_e : s_e;
            if (ev_t[i] != t && ok) begin ok = 1'b0; first_bad = i; end
        end
        check(ok, "R2 R5 edge timing (index)", first_bad, -1);
        // R3 R4 R5: rated enable exactly on launch and capture
        ok = 1'b1; first_bad = -1;
        for (int i = 0; i < nexp && i < n_ev; i++)
            if (ev_r[i] != (i == l_e || i == l_e + 1) && ok) begin ok = 1'b0; first_bad = i; end
        check(ok, "R5 rated edge placement (index)", first_bad, -1);
        // R3 R4: scan enable levels per edge
        ok = 1'b1; first_bad = -1;
        for (int i = 0; i < nexp && i < n_ev; i++) begin
            bit se_exp;
            se_exp = !(i == l_e + 1 || (mode && i == l_e));
            if (ev_se[i] != se_exp && ok) begin ok = 1'b0; first_bad = i; end
        end
        check(ok, mode ? "R4 scan_en per edge (index)" : "R3 scan_en per edge (index)", first_bad, -1);
        check((ptake - pbase) == l_e + (mode ? 0 : 1),
              mode ? "R4 pattern bits taken" : "R3 pattern bits taken",
              ptake - pbase, l_e + (mode ? 0 : 1));
        // R6: response bits and timing
        ok = (n_rb == l_e); first_bad = -1;
        for (int k = 0; k < l_e && k < n_rb; k++)
            if ((rb[k] != cap[l_e-1-k] || rv_t[k] != ev_t[l_e+2+k]) && ok) begin ok = 1'b0; first_bad = k; end
        check(ok, "R6 response stream (bit)", first_bad, -1);
        // R7: done timing
        check(n_done == 1 && done_t == ev_t[nexp-1], "R7 done cycle", done_t, ev_t[nexp-1]);
        check(busy == 1'b0, "R7 busy after done", busy, 0);
        // R9
        check(per_err == (!mode && r_e < SETTLE), "R9 per_err", per_err, (!mode && r_e < SETTLE));
        if (poke) begin
            n_fin = n_ev;
            repeat (40) @(negedge clk);
            check(n_ev == n_fin && !busy, "R8 start while busy ignored", n_ev, n_fin);
        end
    endtask

    initial begin : watchdog
        #1500000;
        bad++; total++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int run;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({scan_en, slow_ce, rated_ce, pat_take, resp_valid, done, busy, per_err} == 8'h00,
              "R1 reset outputs",
              {scan_en, slow_ce, rated_ce, pat_take, resp_valid, done, busy, per_err}, 0);
        run = 0;
        for (int m = 0; m < 2; m++)
            for (int li = 0; li < 4; li++)
                for (int sp = 1; sp <= 3; sp += 2)
                    for (int rp = 1; rp <= 4; rp *= 2) begin
                        int lens [4] = '{1, 2, 3, 7};
                        run_test(m[0], lens[li], sp, rp, 32'hA5C3_1E97 ^ (run * 32'h9E37_79B9), 1'b0);
                        run++;
                    end
        // R10: zero settings act as one
        run_test(1'b0, 0, 0, 0, 32'h0000_0003, 1'b0);
        run_test(1'b1, 0, 0, 0, 32'h0000_0001, 1'b0);
        // R8: start during a run
        run_test(1'b0, 5, 2, 3, 32'h1234_5678, 1'b1);
        run_test(1'b1, 4, 3, 1, 32'h8765_4321, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule